// File: doc/BRIEF.md
# Width-Converting Pack/Unpack Buffer

This block moves data between two valid/ready streams whose word widths differ by a whole-number factor. When the input word is narrower than the output word, consecutive input words are gathered into one wide word, which is then released in a single transfer. When the input word is wider, one accepted word is handed out as a train of narrow words, one per output transfer. When both widths match, the block behaves as a one-entry FIFO.

The operating mode follows from the two width parameters alone. The storage register is as wide as the wider of the two words. No partial words and no byte masks are supported. A fill-level output reports occupancy, counted in narrow-word units. A synchronous flush input empties the buffer.

Top module: `width_pack_buffer`

## Requirements
- R1: After reset (rst_n low at a clock edge), fill_level is 0, out_valid is 0 and in_ready is 1.
- R2: With IN_W < OUT_W, accepted input words fill the output word from the least significant slice upward. The first word lands in bits [IN_W-1:0]. out_valid rises only after OUT_W/IN_W words have been accepted.
- R3: In pack mode, fill_level equals the number of input words accepted since the buffer was last emptied. A cycle without a handshake leaves it unchanged.
- R4: In pack mode, in_ready is low while a complete output word is held. A write offered in that state changes neither the data nor fill_level.
- R5: In pack mode, a pop (out_valid and out_ready high) empties the buffer at that edge. After the edge, fill_level is 0, out_valid is 0 and in_ready is 1. No write is taken in the pop cycle.
- R6: With IN_W > OUT_W, one accepted input word is presented as IN_W/OUT_W output words, least significant slice first, with one slice per pop.
- R7: In unpack mode, fill_level counts the slices still to be read. in_ready stays low until the last slice has been popped.
- R8: With IN_W == OUT_W, the block holds at most one word, and in_ready is always the inverse of out_valid.
- R9: flush high at a clock edge empties the buffer (fill_level 0, out_valid 0). This takes priority over any write or pop handshake in the same cycle, and no earlier slice remains in later output.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous clear of all storage |
| in_valid | input | 1 | Input word offered |
| in_data | input | IN_W | Input word |
| in_ready | output | 1 | Buffer can take an input word |
| out_valid | output | 1 | Output word available |
| out_data | output | OUT_W | Output word |
| out_ready | input | 1 | Consumer takes the output word |
| fill_level | output | clog2(ratio+1) | Occupancy in narrow-word units |

## Verification
The properties assume that a producer may hold in_valid high while in_ready is low and that the block then simply ignores the word. They also assume that flush may arrive together with any handshake. The bench drives inputs only between clock edges and deliberately offers writes while the buffer is full or draining. It also asserts flush together with live write and pop handshakes. This keeps the checked stall, priority and hold behaviour inside what the properties cover.

// File: rtl/wpb_pkg.sv
// Package: shared helpers for the pack/unpack buffer.
// Assumes widths are positive and the larger is an exact multiple of the smaller.
package wpb_pkg;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_PACK   = 2'd1,
        MODE_UNPACK = 2'd2
    } wpb_mode_e;

    // Larger of two widths.
    function automatic int wide_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Smaller of two widths.
    function automatic int narrow_of(input int a, input int b);
        return (a > b) ? b : a;
    endfunction

    // Mode chosen purely from the width relation.
    function automatic wpb_mode_e mode_of(input int in_w, input int out_w);
        if (in_w < out_w) return MODE_PACK;
        if (in_w > out_w) return MODE_UNPACK;
        return MODE_PASS;
    endfunction

    // Bits needed to count 0..ratio.
    function automatic int fill_bits(input int in_w, input int out_w);
        return $clog2(wide_of(in_w, out_w) / narrow_of(in_w, out_w) + 1);
    endfunction

endpackage

// File: rtl/wpb_pack_path.sv
// Module: gathers RATIO narrow input words into one wide output word.
// Assumes OUT_W == RATIO*IN_W. Slice 0 is the least significant slice. No write
// is accepted while a complete word is held, including the pop cycle.
module wpb_pack_path #(
    parameter int IN_W   = 8,
    parameter int OUT_W  = 32,
    parameter int RATIO  = 4,
    parameter int FILL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data,
    input  logic              out_ready,
    output logic [FILL_W-1:0] fill_level
);

    localparam logic [FILL_W-1:0] FULL_CNT = FILL_W'(RATIO);

    logic [OUT_W-1:0]  acc_q;
    logic [FILL_W-1:0] cnt_q;
    logic              full;
    logic              take;
    logic              pop;

    // Handshake decode from the slice counter.
    always_comb begin
        full = (cnt_q == FULL_CNT);
        take = in_valid && !full;
        pop  = full && out_ready;
    end

    // Accumulate slices; flush and pop clear everything.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (pop) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            for (int k = 0; k < RATIO; k++) begin
                if (cnt_q == FILL_W'(k)) acc_q[k*IN_W +: IN_W] <= in_data;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Port outputs.
    always_comb begin
        in_ready   = !full;
        out_valid  = full;
        out_data   = acc_q;
        fill_level = cnt_q;
    end

endmodule

// File: rtl/wpb_unpack_path.sv
// Module: splits one wide input word into RATIO narrow output words.
// Assumes IN_W == RATIO*OUT_W. The least significant slice leaves first. A new
// word is accepted only once the buffer is fully drained.
module wpb_unpack_path #(
    parameter int IN_W   = 32,
    parameter int OUT_W  = 8,
    parameter int RATIO  = 4,
    parameter int FILL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data,
    input  logic              out_ready,
    output logic [FILL_W-1:0] fill_level
);

    logic [IN_W-1:0]   shreg_q;
    logic [FILL_W-1:0] left_q;
    logic              empty;
    logic              take;
    logic              pop;

    // Handshake decode from the remaining-slice counter.
    always_comb begin
        empty = (left_q == '0);
        take  = in_valid && empty;
        pop   = !empty && out_ready;
    end

    // Load a wide word, then shift one slice out per pop.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            shreg_q <= '0;
            left_q  <= '0;
        end else if (take) begin
            shreg_q <= in_data;
            left_q  <= FILL_W'(RATIO);
        end else if (pop) begin
            shreg_q <= shreg_q >> OUT_W;
            left_q  <= left_q - 1'b1;
        end
    end

    // Port outputs.
    always_comb begin
        in_ready   = empty;
        out_valid  = !empty;
        out_data   = shreg_q[OUT_W-1:0];
        fill_level = left_q;
    end

endmodule

// File: rtl/wpb_pass_path.sv
// Module: one-entry FIFO used when input and output widths match.
// Assumes IN_W == OUT_W and FILL_W >= 1.
module wpb_pass_path #(
    parameter int W      = 16,
    parameter int FILL_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [W-1:0]      in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [W-1:0]      out_data,
    input  logic              out_ready,
    output logic [FILL_W-1:0] fill_level
);

    logic [W-1:0] data_q;
    logic         full_q;

    // Hold one word until popped.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else if (full_q && out_ready) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else if (!full_q && in_valid) begin
            data_q <= in_data;
            full_q <= 1'b1;
        end
    end

    // Port outputs.
    always_comb begin
        in_ready   = !full_q;
        out_valid  = full_q;
        out_data   = data_q;
        fill_level = FILL_W'(full_q);
    end

endmodule

// File: rtl/width_pack_buffer.sv
// Module: width-converting buffer. Selects pack, unpack or one-entry mode from
// the width parameters. Assumes the wider width is an exact multiple of the
// narrower one. Reset is synchronous and active low; flush is a synchronous clear.
module width_pack_buffer
    import wpb_pkg::*;
#(
    parameter  int IN_W   = 8,
    parameter  int OUT_W  = 32,
    localparam int FILL_W = fill_bits(IN_W, OUT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data,
    input  logic              out_ready,
    output logic [FILL_W-1:0] fill_level
);

    localparam int        WIDE_W   = wide_of(IN_W, OUT_W);
    localparam int        NARROW_W = narrow_of(IN_W, OUT_W);
    localparam int        RATIO    = WIDE_W / NARROW_W;
    localparam wpb_mode_e MODE     = mode_of(IN_W, OUT_W);

    // Pick the datapath variant that matches the width relation.
    if (MODE == MODE_PACK) begin : g_pack
        wpb_pack_path #(
            .IN_W(IN_W), .OUT_W(OUT_W), .RATIO(RATIO), .FILL_W(FILL_W)
        ) u_path (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
            .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
            .fill_level(fill_level)
        );
    end else if (MODE == MODE_UNPACK) begin : g_unpack
        wpb_unpack_path #(
            .IN_W(IN_W), .OUT_W(OUT_W), .RATIO(RATIO), .FILL_W(FILL_W)
        ) u_path (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
            .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
            .fill_level(fill_level)
        );
    end else begin : g_pass
        wpb_pass_path #(
            .W(IN_W), .FILL_W(FILL_W)
        ) u_path (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
            .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
            .fill_level(fill_level)
        );
    end

endmodule

// File: rtl/wpb_checker.sv
// Module: protocol properties for width_pack_buffer, attached through bind.
// Assumes the same parameters as the bound instance.
module wpb_checker
    import wpb_pkg::*;
#(
    parameter  int IN_W   = 8,
    parameter  int OUT_W  = 32,
    localparam int FILL_W = fill_bits(IN_W, OUT_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_data,
    input logic              out_ready,
    input logic [FILL_W-1:0] fill_level
);

    localparam int        RATIO   = wide_of(IN_W, OUT_W) / narrow_of(IN_W, OUT_W);
    localparam wpb_mode_e MODE    = mode_of(IN_W, OUT_W);
    localparam logic      IS_PACK = (MODE == MODE_PACK);

    // R4 / R7 / R8: the two ready/valid outputs never agree
    assert_ready_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == !out_valid);

    // R3: occupancy never exceeds the ratio
    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= FILL_W'(RATIO));

    // R3: each pack-mode accepted write adds exactly one
    assert_fill_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_PACK && in_valid && in_ready && !flush) |=> fill_level == $past(fill_level) + 1'b1);

    // R5: a pack-mode pop empties the buffer
    assert_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_PACK && out_valid && out_ready) |=> (fill_level == '0 && in_ready));

    // R9: flush empties regardless of handshakes
    assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill_level == '0 && !out_valid));

    // R10: a stalled output holds
    assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

endmodule

bind width_pack_buffer wpb_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .fill_level(fill_level)
);

// File: tb/sim_width_pack_buffer.sv
// Bench: directed scenarios on pack (8->32), unpack (32->8) and equal (16->16) instances.
module sim_width_pack_buffer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // pack instance
    logic        pk_flush = 0, pk_iv = 0, pk_ir, pk_ov, pk_or = 0;
    logic [7:0]  pk_id = '0;
    logic [31:0] pk_od;
    logic [2:0]  pk_fl;
    // unpack instance
    logic        up_flush = 0, up_iv = 0, up_ir, up_ov, up_or = 0;
    logic [31:0] up_id = '0;
    logic [7:0]  up_od;
    logic [2:0]  up_fl;
    // equal-width instance
    logic        ps_flush = 0, ps_iv = 0, ps_ir, ps_ov, ps_or = 0;
    logic [15:0] ps_id = '0;
    logic [15:0] ps_od;
    logic [0:0]  ps_fl;

    width_pack_buffer #(.IN_W(8), .OUT_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(pk_flush), .in_valid(pk_iv), .in_data(pk_id),
        .in_ready(pk_ir), .out_valid(pk_ov), .out_data(pk_od), .out_ready(pk_or),
        .fill_level(pk_fl));
    width_pack_buffer #(.IN_W(32), .OUT_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .flush(up_flush), .in_valid(up_iv), .in_data(up_id),
        .in_ready(up_ir), .out_valid(up_ov), .out_data(up_od), .out_ready(up_or),
        .fill_level(up_fl));
    width_pack_buffer #(.IN_W(16), .OUT_W(16)) u2 (
        .clk(clk), .rst_n(rst_n), .flush(ps_flush), .in_valid(ps_iv), .in_data(ps_id),
        .in_ready(ps_ir), .out_valid(ps_ov), .out_data(ps_od), .out_ready(ps_or),
        .fill_level(ps_fl));

    // Compare one value and log a failure.
    task automatic check(input string req, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Advance one edge; inputs change and outputs are sampled 1 ns later.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pk_write(input logic [7:0] d);
        pk_iv = 1; pk_id = d; tick(); pk_iv = 0;
    endtask

    task automatic t_reset();
        check("R1", "pack fill", pk_fl, 0);
        check("R1", "pack valid", pk_ov, 0);
        check("R1", "pack ready", pk_ir, 1);
        check("R1", "unpack fill", up_fl, 0);
        check("R1", "unpack ready", up_ir, 1);
        check("R1", "equal valid", ps_ov, 0);
    endtask

    task automatic t_pack();
        logic [7:0] w [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        for (int i = 0; i < 4; i++) begin
            check("R2", "valid before full", pk_ov, 0);
            pk_write(w[i]);
            check("R3", "fill count", pk_fl, i + 1);
        end
        check("R2", "valid when full", pk_ov, 1);
        check("R2", "packed word lsb first", pk_od, 32'h44332211);
        // idle cycle keeps fill
        tick();
        check("R3", "fill held idle", pk_fl, 4);
        // write offered while full
        check("R4", "ready low when full", pk_ir, 0);
        pk_write(8'h99);
        check("R4", "data unchanged", pk_od, 32'h44332211);
        check("R4", "fill unchanged", pk_fl, 4);
        // stalled pop holds data
        check("R10", "held while stalled", pk_od, 32'h44332211);
        // pop with a write offered in the same cycle
        pk_or = 1; pk_iv = 1; pk_id = 8'h5A; tick(); pk_or = 0; pk_iv = 0;
        check("R5", "fill after pop", pk_fl, 0);
        check("R5", "valid after pop", pk_ov, 0);
        check("R5", "ready after pop", pk_ir, 1);
        // second pattern with gaps
        pk_write(8'hA0); tick(); pk_write(8'hB1); pk_write(8'hC2); tick(); pk_write(8'hD3);
        check("R2", "second word", pk_od, 32'hD3C2B1A0);
        pk_or = 1; tick(); pk_or = 0;
    endtask

    task automatic t_unpack();
        up_iv = 1; up_id = 32'hA1B2C3D4; tick(); up_iv = 0;
        check("R7", "fill after load", up_fl, 4);
        check("R6", "first slice", up_od, 8'hD4);
        check("R7", "ready low after load", up_ir, 0);
        tick();
        check("R10", "stalled slice", up_od, 8'hD4);
        check("R10", "stalled valid", up_ov, 1);
        // offer a write during drain, it must be ignored
        up_iv = 1; up_id = 32'hFFFFFFFF; up_or = 1; tick();
        check("R6", "second slice", up_od, 8'hC3);
        check("R7", "fill three", up_fl, 3);
        tick();
        check("R6", "third slice", up_od, 8'hB2);
        up_iv = 0;
        tick();
        check("R6", "fourth slice", up_od, 8'hA1);
        check("R7", "ready still low", up_ir, 0);
        tick(); up_or = 0;
        check("R7", "drained fill", up_fl, 0);
        check("R7", "ready after drain", up_ir, 1);
        check("R7", "valid after drain", up_ov, 0);
    endtask

    task automatic t_pass();
        ps_iv = 1; ps_id = 16'hBEEF; tick();
        check("R8", "valid", ps_ov, 1);
        check("R8", "ready inverse", ps_ir, 0);
        check("R8", "fill one", ps_fl, 1);
        ps_id = 16'h1234; tick(); ps_iv = 0;
        check("R8", "second write ignored", ps_od, 16'hBEEF);
        ps_or = 1; tick(); ps_or = 0;
        check("R8", "empty after pop", ps_ov, 0);
        check("R8", "ready after pop", ps_ir, 1);
    endtask

    task automatic t_flush();
        pk_write(8'hEE); pk_write(8'hDD);
        pk_flush = 1; pk_iv = 1; pk_id = 8'h77; tick(); pk_flush = 0; pk_iv = 0;
        check("R9", "pack fill after flush", pk_fl, 0);
        pk_write(8'h01); pk_write(8'h02); pk_write(8'h03); pk_write(8'h04);
        check("R9", "no stale slice", pk_od, 32'h04030201);
        pk_flush = 1; pk_or = 1; tick(); pk_flush = 0; pk_or = 0;
        check("R9", "pack empty after flush+pop", pk_ov, 0);
        up_iv = 1; up_id = 32'h01020304; tick(); up_iv = 0;
        up_flush = 1; up_or = 1; up_iv = 1; tick(); up_flush = 0; up_or = 0; up_iv = 0;
        check("R9", "unpack fill after flush", up_fl, 0);
        check("R9", "unpack valid after flush", up_ov, 0);
        ps_iv = 1; ps_id = 16'h5555; tick(); ps_iv = 0;
        ps_flush = 1; tick(); ps_flush = 0;
        check("R9", "equal empty after flush", ps_ov, 0);
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    // Main sequence.
    initial begin
        #1;
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_pack();
        t_unpack();
        t_pass();
        t_flush();
        repeat (2) tick();
        finish_up();
    end

endmodule